// File: doc/BRIEF.md
# PHY Link State Qualifier

This block turns raw PHY status samples into a debounced link state (UNKNOWN, DOWN or UP) together with the negotiated speed and duplex. The management logic polls the PHY and hands each sample to the block on a one-cycle valid strobe. A sample carries three things: the 16-bit basic status word, the autonegotiation-enable setting currently programmed into the PHY, and five vendor status bits (link good, signal present, running at 10, running at 100, full duplex).

The block keeps a copy of the last status word. Whenever a new word differs from that copy, it restarts a settle window that is counted in system clock ticks. A loss of link on an UP link is accepted at once. A rise to UP is accepted only after the status word has been stable for the whole settle window, autonegotiation has completed or is disabled, and the vendor bits agree. Moves into and out of UP raise a one-cycle report pulse and advance a link-up or a link-drop counter. Moves between DOWN and UNKNOWN are silent.

Top module: `phy_link_qual`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters state UNKNOWN (`link_state` 0), speed none (`link_speed` 0), duplex unknown (`link_duplex` 0), `report_pulse` 0 and both counters 0. The stored status word becomes 0 and the settle age restarts from 0.
- R2: A sample is evaluated only in a cycle with `sample_valid` high, and the outputs change at the clock edge that takes it. With `sample_valid` low, state, speed, duplex and counters hold and `report_pulse` is 0, whatever the other inputs do.
- R3: A sample whose word differs from the stored word replaces the stored word and restarts the settle age at 0. If R4 and R5 do not apply and the sample either changed the word or arrived fewer than `SETTLE_TICKS` clock cycles after the last change, the candidate state is UNKNOWN.
- R4: A status word of 0xFFFF always gives DOWN.
- R5: When the current state is UP and link-up bit 2 of the word is clear, the state becomes DOWN at once, even inside the settle window.
- R6: Once settled, the candidate follows bit 2 (set gives UP, clear gives DOWN). The exception is when autonegotiation-complete bit 5 is clear and `an_enable` is high: then the candidate is DOWN.
- R7: A candidate UP becomes UNKNOWN unless `vs_link_ok` and `vs_signal` are both high and exactly one of `vs_at10` and `vs_at100` is high.
- R8: On entering UP, `link_speed` becomes 2 (100) if `vs_at100` is high and 1 (10) otherwise. `link_duplex` becomes 2 (full) if `vs_full_duplex` is high and 1 (half) otherwise. `report_pulse` is high for that one cycle. Speed and duplex hold while the state stays UP.
- R9: On leaving UP (to DOWN or UNKNOWN), `report_pulse` is high for one cycle, `link_speed` returns to 0 and `link_duplex` to 0. A change between DOWN and UNKNOWN gives no pulse.
- R10: `up_count` increments by one on each entry to UP, and `drop_count` increments by one on each departure from UP. Both wrap at their width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_valid | input | 1 | One-cycle strobe marking a new status sample |
| status_word | input | 16 | Basic status word; bit 2 is link up, bit 5 is autonegotiation complete |
| an_enable | input | 1 | Autonegotiation is enabled in the PHY |
| vs_link_ok | input | 1 | Vendor status: link good |
| vs_signal | input | 1 | Vendor status: signal detected on the line |
| vs_at10 | input | 1 | Vendor status: running at 10 Mb/s |
| vs_at100 | input | 1 | Vendor status: running at 100 Mb/s |
| vs_full_duplex | input | 1 | Vendor status: full duplex |
| link_state | output | 2 | 0 UNKNOWN, 1 DOWN, 2 UP |
| link_speed | output | 2 | 0 none, 1 10 Mb/s, 2 100 Mb/s |
| link_duplex | output | 2 | 0 unknown, 1 half, 2 full |
| report_pulse | output | 1 | One-cycle pulse on a reported state change |
| up_count | output | CNT_W | Number of reported entries to UP |
| drop_count | output | CNT_W | Number of reported departures from UP |

## Verification
On every cycle the assertions check four things. The outputs hold when no sample arrives. A dead 0xFFFF word or a lost link bit never leaves the block in UP. Speed and duplex are non-zero exactly while the state is UP. Every entry to or exit from UP comes with a report pulse and the matching counter step. Only the bench's scenarios can show the timing side: a rise to UP waits out the settle window after a word change, autonegotiation must be complete when it is enabled, the vendor bits can veto UP, and DOWN/UNKNOWN changes stay silent.

// File: rtl/phy_lq_pkg.sv
// Shared types and constants for the PHY link state qualifier.
// Assumes the standard basic status word layout: bit 2 is link up,
// bit 5 is autonegotiation complete.
package phy_lq_pkg;

    typedef enum logic [1:0] {
        LS_UNKNOWN = 2'd0,
        LS_DOWN    = 2'd1,
        LS_UP      = 2'd2
    } link_state_e;

    typedef enum logic [1:0] {
        SPD_NONE = 2'd0,
        SPD_10   = 2'd1,
        SPD_100  = 2'd2
    } link_speed_e;

    typedef enum logic [1:0] {
        DPX_UNKNOWN = 2'd0,
        DPX_HALF    = 2'd1,
        DPX_FULL    = 2'd2
    } link_duplex_e;

    typedef struct packed {
        logic link_ok;
        logic signal;
        logic at10;
        logic at100;
        logic full_dpx;
    } vend_status_t;

    localparam int          WORD_W      = 16;
    localparam int          LINK_BIT    = 2;
    localparam int          AN_DONE_BIT = 5;
    localparam logic [15:0] DEAD_WORD   = 16'hFFFF;

endpackage

// File: rtl/lq_status_age.sv
// Status word tracker: holds the last sampled status word and counts the
// clock cycles since it last changed, saturating at SETTLE_TICKS.
// Assumes SETTLE_TICKS >= 1. The age restarts on reset and on any change.
module lq_status_age #(
    parameter int WORD_W       = 16,
    parameter int SETTLE_TICKS = 375_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [WORD_W-1:0] word_in,
    output logic              word_changed,
    output logic              settled
);
    localparam int AGE_W = $clog2(SETTLE_TICKS + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(SETTLE_TICKS);

    logic [WORD_W-1:0] stored_word;
    logic [AGE_W-1:0]  age;

    // A valid sample that differs from the stored copy counts as a change.
    always_comb word_changed = sample_valid && (word_in != stored_word);

    // Settled means the word is unchanged and a full window has elapsed.
    always_comb settled = !word_changed && (age >= AGE_MAX);

    // Capture the new word and restart the age, or let the age grow to its cap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored_word <= '0;
            age         <= '0;
        end else if (word_changed) begin
            stored_word <= word_in;
            age         <= '0;
        end else if (age < AGE_MAX) begin
            age <= age + 1'b1;
        end
    end
endmodule

// File: rtl/lq_state_judge.sv
// Candidate state judge: applies the qualification rules, in priority order,
// to one sample. Purely combinational; the caller registers the result.
module lq_state_judge
    import phy_lq_pkg::*;
(
    input  logic         dead_word,
    input  logic         link_bit,
    input  logic         an_done,
    input  logic         an_enable,
    input  logic         settled,
    input  vend_status_t vend,
    input  link_state_e  cur_state,
    output link_state_e  cand_state
);
    link_state_e raw_state;
    link_state_e ruled;
    logic        vend_ok;

    // Raw view from the link-up bit alone.
    always_comb raw_state = link_bit ? LS_UP : LS_DOWN;

    // The vendor bits must show a live link at exactly one speed.
    always_comb vend_ok = vend.link_ok && vend.signal && (vend.at10 ^ vend.at100);

    // Priority chain: dead word, fast drop, settle window, autonegotiation.
    always_comb begin
        if (dead_word)
            ruled = LS_DOWN;
        else if (cur_state == LS_UP && raw_state == LS_DOWN)
            ruled = LS_DOWN;
        else if (!settled)
            ruled = LS_UNKNOWN;
        else if (an_done)
            ruled = raw_state;
        else if (an_enable)
            ruled = LS_DOWN;
        else
            ruled = raw_state;
    end

    // A candidate UP the vendor bits disagree with is downgraded to UNKNOWN.
    always_comb cand_state = (ruled == LS_UP && !vend_ok) ? LS_UNKNOWN : ruled;
endmodule

// File: rtl/lq_reporter.sv
// Link reporter: registers the qualified state, latches speed and duplex on
// entry to UP, clears them on exit, pulses a report and counts both events.
module lq_reporter
    import phy_lq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_valid,
    input  link_state_e        cand_state,
    input  vend_status_t       vend,
    output link_state_e        state_q,
    output link_speed_e        speed_q,
    output link_duplex_e       duplex_q,
    output logic               report_q,
    output logic [CNT_W-1:0]   up_cnt,
    output logic [CNT_W-1:0]   drop_cnt
);
    localparam int N_EVT = 2;

    logic             enter_up;
    logic             leave_up;
    logic [N_EVT-1:0] evt;
    logic [CNT_W-1:0] cnt [N_EVT];

    // Classify this sample's transition relative to the held state.
    always_comb begin
        enter_up = sample_valid && cand_state == LS_UP && state_q != LS_UP;
        leave_up = sample_valid && cand_state != LS_UP && state_q == LS_UP;
        evt      = {leave_up, enter_up};
    end

    // Hold state, speed and duplex; update them only on a valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= LS_UNKNOWN;
            speed_q  <= SPD_NONE;
            duplex_q <= DPX_UNKNOWN;
            report_q <= 1'b0;
        end else begin
            report_q <= enter_up || leave_up;
            if (sample_valid)
                state_q <= cand_state;
            if (enter_up) begin
                speed_q  <= vend.at100 ? SPD_100 : SPD_10;
                duplex_q <= vend.full_dpx ? DPX_FULL : DPX_HALF;
            end else if (leave_up) begin
                speed_q  <= SPD_NONE;
                duplex_q <= DPX_UNKNOWN;
            end
        end
    end

    // One wrapping event counter per reported transition kind.
    for (genvar gi = 0; gi < N_EVT; gi++) begin : g_evt_cnt
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt[gi] <= '0;
            else if (evt[gi])
                cnt[gi] <= cnt[gi] + 1'b1;
        end
    end

    assign up_cnt   = cnt[0];
    assign drop_cnt = cnt[1];
endmodule

// File: rtl/phy_link_qual.sv
// PHY link state qualifier top: combines the status age tracker, the state
// judge and the reporter. Samples arrive on sample_valid; all outputs are
// registered and change at the edge that takes a sample.
module phy_link_qual
    import phy_lq_pkg::*;
#(
    parameter int SETTLE_TICKS = 375_000_000,
    parameter int CNT_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [15:0]       status_word,
    input  logic              an_enable,
    input  logic              vs_link_ok,
    input  logic              vs_signal,
    input  logic              vs_at10,
    input  logic              vs_at100,
    input  logic              vs_full_duplex,
    output logic [1:0]        link_state,
    output logic [1:0]        link_speed,
    output logic [1:0]        link_duplex,
    output logic              report_pulse,
    output logic [CNT_W-1:0]  up_count,
    output logic [CNT_W-1:0]  drop_count
);
    vend_status_t vend;
    logic         word_changed;
    logic         settled;
    logic         dead_word;
    link_state_e  cand_state;
    link_state_e  state_q;
    link_speed_e  speed_q;
    link_duplex_e duplex_q;

    // Gather the vendor bits into one record.
    always_comb vend = '{link_ok: vs_link_ok, signal: vs_signal, at10: vs_at10,
                         at100: vs_at100, full_dpx: vs_full_duplex};

    // An all-ones word means no PHY answered.
    always_comb dead_word = (status_word == DEAD_WORD);

    lq_status_age #(
        .WORD_W       (WORD_W),
        .SETTLE_TICKS (SETTLE_TICKS)
    ) u_age (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .word_in      (status_word),
        .word_changed (word_changed),
        .settled      (settled)
    );

    lq_state_judge u_judge (
        .dead_word  (dead_word),
        .link_bit   (status_word[LINK_BIT]),
        .an_done    (status_word[AN_DONE_BIT]),
        .an_enable  (an_enable),
        .settled    (settled),
        .vend       (vend),
        .cur_state  (state_q),
        .cand_state (cand_state)
    );

    lq_reporter #(
        .CNT_W (CNT_W)
    ) u_rep (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .cand_state   (cand_state),
        .vend         (vend),
        .state_q      (state_q),
        .speed_q      (speed_q),
        .duplex_q     (duplex_q),
        .report_q     (report_pulse),
        .up_cnt       (up_count),
        .drop_cnt     (drop_count)
    );

    assign link_state  = state_q;
    assign link_speed  = speed_q;
    assign link_duplex = duplex_q;
endmodule

// File: rtl/phy_link_qual_chk.sv
// Property checker for the PHY link state qualifier, bound to the top.
// Watches ports only; every property is disabled while reset is low.
module phy_link_qual_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_valid,
    input logic [15:0]      status_word,
    input logic [1:0]       link_state,
    input logic [1:0]       link_speed,
    input logic [1:0]       link_duplex,
    input logic             report_pulse,
    input logic [CNT_W-1:0] up_count,
    input logic [CNT_W-1:0] drop_count
);
    localparam logic [1:0] UP   = 2'd2;
    localparam logic [1:0] DOWN = 2'd1;

    // Without a sample the state holds and no report is raised.
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> ($stable(link_state) && !report_pulse));

    // A dead word never leaves the link UP.
    assert_dead_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && status_word == 16'hFFFF) |=> link_state == DOWN);

    // A lost link bit on an UP link drops it on the next edge.
    assert_fast_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && link_state == UP && !status_word[2]) |=> link_state == DOWN);

    // Speed and duplex are known exactly while UP.
    assert_speed_while_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == UP) == (link_speed != 2'd0 && link_duplex != 2'd0));

    // Entering UP raises a report and advances the up counter.
    assert_enter_counts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == UP && $past(link_state) != UP) |->
        (report_pulse && up_count == CNT_W'($past(up_count) + 1'b1)));

    // Leaving UP raises a report and advances the drop counter.
    assert_leave_counts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state != UP && $past(link_state) == UP) |->
        (report_pulse && drop_count == CNT_W'($past(drop_count) + 1'b1)));

    // DOWN and UNKNOWN swap without a report.
    assert_silent_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state != UP && $past(link_state) != UP) |-> !report_pulse);
endmodule

bind phy_link_qual phy_link_qual_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .status_word  (status_word),
    .link_state   (link_state),
    .link_speed   (link_speed),
    .link_duplex  (link_duplex),
    .report_pulse (report_pulse),
    .up_count     (up_count),
    .drop_count   (drop_count)
);

// File: tb/phy_link_qual_tb.sv
// Self-checking bench for the PHY link state qualifier.
module phy_link_qual_tb;
    localparam int SETTLE = 20;
    localparam int CW     = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sample_valid = 1'b0;
    logic [15:0]   status_word = '0;
    logic          an_enable = 1'b0;
    logic [4:0]    vend = '0;  // {link_ok, signal, at10, at100, full_duplex}
    logic [1:0]    link_state, link_speed, link_duplex;
    logic          report_pulse;
    logic [CW-1:0] up_count, drop_count;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    phy_link_qual #(.SETTLE_TICKS(SETTLE), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .status_word(status_word), .an_enable(an_enable),
        .vs_link_ok(vend[4]), .vs_signal(vend[3]), .vs_at10(vend[2]),
        .vs_at100(vend[1]), .vs_full_duplex(vend[0]),
        .link_state(link_state), .link_speed(link_speed), .link_duplex(link_duplex),
        .report_pulse(report_pulse), .up_count(up_count), .drop_count(drop_count)
    );

    localparam logic [4:0] V100F = 5'b11011;
    localparam logic [4:0] V10H  = 5'b11100;
    localparam logic [4:0] VBOTH = 5'b11110;
    localparam logic [4:0] VNOSG = 5'b10010;

    // {idle cycles, word, an_enable, vendor, exp state, exp speed, exp duplex, exp report}
    localparam int NV = 13;
    localparam logic [36:0] VEC [NV] = '{
        {8'd30, 16'h7824, 1'b1, V100F, 2'd0, 2'd0, 2'd0, 1'b0}, // R3 change -> UNKNOWN
        {8'd30, 16'h7824, 1'b1, V100F, 2'd2, 2'd2, 2'd2, 1'b1}, // R6 R8 settled UP 100 full
        {8'd0,  16'h7824, 1'b1, V100F, 2'd2, 2'd2, 2'd2, 1'b0}, // R8 stays UP, no report
        {8'd0,  16'h7820, 1'b1, V100F, 2'd1, 2'd0, 2'd0, 1'b1}, // R5 R9 fast drop
        {8'd0,  16'h7824, 1'b1, V100F, 2'd0, 2'd0, 2'd0, 1'b0}, // R3 R9 silent DOWN->UNKNOWN
        {8'd5,  16'h7824, 1'b1, V100F, 2'd0, 2'd0, 2'd0, 1'b0}, // R3 inside window
        {8'd30, 16'h7804, 1'b1, V100F, 2'd0, 2'd0, 2'd0, 1'b0}, // R3 change
        {8'd30, 16'h7804, 1'b1, V100F, 2'd1, 2'd0, 2'd0, 1'b0}, // R6 AN incomplete -> DOWN
        {8'd0,  16'h7804, 1'b0, V10H,  2'd2, 2'd1, 2'd1, 1'b1}, // R6 R8 AN off, UP 10 half
        {8'd0,  16'h7804, 1'b0, VBOTH, 2'd0, 2'd0, 2'd0, 1'b1}, // R7 R9 veto leaves UP
        {8'd0,  16'h7804, 1'b0, VNOSG, 2'd0, 2'd0, 2'd0, 1'b0}, // R7 no signal stays UNKNOWN
        {8'd30, 16'hFFFF, 1'b0, V100F, 2'd1, 2'd0, 2'd0, 1'b0}, // R4 dead word
        {8'd30, 16'hFFFF, 1'b0, V100F, 2'd1, 2'd0, 2'd0, 1'b0}  // R4 settled dead word
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Idle for w edges, present one sample, then sample results at the next negedge.
    task automatic do_sample(input int w, input logic [15:0] word, input logic an,
                             input logic [4:0] vs);
        repeat (w) @(negedge clk);
        status_word  = word;
        an_enable    = an;
        vend         = vs;
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic check_reset_state(input string tag);
        check("R1", {tag, " state"},  link_state, 0);
        check("R1", {tag, " speed"},  link_speed, 0);
        check("R1", {tag, " duplex"}, link_duplex, 0);
        check("R1", {tag, " report"}, report_pulse, 0);
        check("R1", {tag, " up"},     up_count, 0);
        check("R1", {tag, " drop"},   drop_count, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check_reset_state("reset");  // R1
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [36:0] v;
            v = VEC[i];
            do_sample(int'(v[36:29]), v[28:13], v[12], v[11:7]);
            check("R3-R9", $sformatf("vec%0d state", i), link_state, int'(v[6:5]));
            check("R8", $sformatf("vec%0d speed", i), link_speed, int'(v[4:3]));
            check("R8", $sformatf("vec%0d duplex", i), link_duplex, int'(v[2:1]));
            check("R9", $sformatf("vec%0d report", i), report_pulse, int'(v[0]));
        end
        check("R10", "up count after table", up_count, 2);
        check("R10", "drop count after table", drop_count, 2);

        // Climb back to UP after a word change: unknown first, then UP after settle.
        do_sample(0, 16'h7824, 1'b1, V100F);
        check("R3", "change from dead word", link_state, 0);
        do_sample(30, 16'h7824, 1'b1, V100F);
        check("R8", "UP again", link_state, 2);
        @(negedge clk);
        check("R8", "report lasts one cycle", report_pulse, 0);

        // R2: inputs wiggle without a strobe; nothing moves.
        status_word = 16'h0000;
        an_enable   = 1'b1;
        vend        = VBOTH;
        repeat (10) @(negedge clk);
        check("R2", "state held without strobe", link_state, 2);
        check("R2", "speed held without strobe", link_speed, 2);
        check("R2", "no report without strobe", report_pulse, 0);

        // R4 on an UP link: dead word drops it with a report.
        do_sample(0, 16'hFFFF, 1'b0, V100F);
        check("R4", "dead word drops UP", link_state, 1);
        check("R9", "dead word drop report", report_pulse, 1);
        check("R10", "final up count", up_count, 3);
        check("R10", "final drop count", drop_count, 3);

        // R1: reset in the middle of a run.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_reset_state("mid reset");
        rst_n = 1'b1;
        // R1 stored word 0: a zero word right after reset is not a change.
        do_sample(SETTLE + 2, 16'h0000, 1'b0, V100F);
        check("R1", "zero word settled after reset", link_state, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule